// File: doc/BRIEF.md
# Dual-Subsystem Interrupt Flag Controller

This block holds the interrupt flag and mask registers for two symmetric processor subsystems, named side 0 and side 1. On each side, single-cycle event pulses from a timer, two external pins, a host port, three serial ports and six DMA channels are caught in a 16-bit flag register. A 16-bit mask register with the same layout enables each flag. Four flag positions are shared. For each one, a select bit in the side's control register decides whether a serial-port event or a DMA-channel event sets it.

Each side has a doorbell request bit in its control register. A small two-state machine (states `RQ_LOW` and `RQ_HIGH`) follows that bit. A write that moves it from `RQ_LOW` to `RQ_HIGH` takes the `RING` transition, which raises the interprocessor flag (bit 14) on the opposite side. A write of 0 takes the `DISARM` transition back to `RQ_LOW`. A write of 1 while the machine is already in `RQ_HIGH` takes the `HOLD` self-loop and rings nothing. For each side, the block drives a masked pending line and the index of the lowest-numbered pending, enabled flag. Software reaches the registers through a single write port and a combinational read port.

Top module: `dual_irq_flag_ctrl`

## Requirements
- R1: After reset, every flag, mask and control register on both sides reads 0, `irq_o` is 0 and both priority indexes are 0.
- R2: Each side's event vector maps to flag bits as follows. Event 0 goes to flag 0, event 1 to flag 1 and event 2 (timer) to flag 3. Event 3 (host) goes to flag 9. Events 4 and 5 (serial 0 rx/tx) go to flags 4 and 5. Events 14 and 15 (DMA 4/5) go to flags 12 and 13.
- R3: A one-cycle event pulse sets its flag at the next clock edge. The flag stays set until software writes 1 to that bit at address 0. Writing 0 to a flag bit has no effect.
- R4: If an event and a write-1-to-clear hit the same flag bit in the same cycle, the flag ends set.
- R5: Address 1 is the mask register. A write replaces it, and reads return the stored value.
- R6: Control bits 1 to 4 pick the source of flags 6, 7, 10 and 11 in that order. A value of 0 picks the serial-port source: events 8, 9, 6 and 7 (serial 2 rx/tx, serial 1 rx/tx). A value of 1 picks the DMA source: events 10, 11, 12 and 13 (DMA 0..3). The source that is not picked has no effect.
- R7: Changing a select bit affects only events that arrive in later cycles. A flag that is already latched keeps its value.
- R8: Control bit 0 (address 2) is the doorbell request. A write that takes it from 0 to 1 sets flag 14 of the other side at the same clock edge. Writing 1 again while it is 1 rings nothing. Once it has been written back to 0, the next write of 1 rings again.
- R9: Flag and mask bits 15, 8 and 2 always read 0, and writes do not change them.
- R10: `irq_o[s]` is 1 exactly when some flag bit of side s is set together with the mask bit at the same position.
- R11: The priority index of a side is the lowest bit position that is both flagged and enabled. When nothing is pending, the index is 0.
- R12: `rd_data_o` is a combinational view of register `rd_addr_i` on side `rd_sub_i`. Address 2 reads `{sel[3:0], req}` in bits 4:0, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sub_i | input | 1 | Side addressed by the write |
| wr_addr_i | input | 2 | Write address: 0 flag, 1 mask, 2 control |
| wr_data_i | input | 16 | Write data |
| rd_sub_i | input | 1 | Side addressed by the read |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 16 | Read data |
| evt0_i | input | 16 | Event pulses for side 0 |
| evt1_i | input | 16 | Event pulses for side 1 |
| irq_o | output | 2 | Masked pending line per side |
| prio0_o | output | 4 | Lowest pending enabled flag index, side 0 |
| prio1_o | output | 4 | Lowest pending enabled flag index, side 1 |

## Verification
The assertions check on every cycle that reserved bits stay clear and that a flag never drops without a write to its flag register. They also check that a doorbell ring lands in the far side's bit 14 and cannot repeat on the next cycle, and that the priority index always names a pending, enabled bit with none below it. Other behaviours can only be shown by the bench's scenarios: the exact event-to-flag map under both select settings, set winning over clear, the rule that a select change does not touch a latched flag, and the full write-0-then-1 sequence that re-arms the doorbell.

// File: rtl/dif_pkg.sv
package dif_pkg;
    localparam int REG_W    = 16;
    localparam int IDX_W    = $clog2(REG_W);
    localparam int NUM_SUB  = 2;
    localparam int NUM_SHR  = 4;
    localparam int ADDR_W   = 2;
    localparam int DB_BIT   = 14;
    localparam logic [REG_W-1:0] RSVD_MASK = 16'h8104;
    localparam logic [REG_W-1:0] IMPL_MASK = ~RSVD_MASK;

    localparam logic [ADDR_W-1:0] A_FLAG = 2'd0;
    localparam logic [ADDR_W-1:0] A_MASK = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd2;

    typedef enum logic {RQ_LOW, RQ_HIGH} rq_state_e;

    // flag position of shared slot k
    function automatic int shr_flag(input int k);
        case (k)
            0: return 6;
            1: return 7;
            2: return 10;
            default: return 11;
        endcase
    endfunction

    // serial event feeding shared slot k
    function automatic int shr_ser(input int k);
        case (k)
            0: return 8;
            1: return 9;
            2: return 6;
            default: return 7;
        endcase
    endfunction

    // DMA event feeding shared slot k
    function automatic int shr_dma(input int k);
        return 10 + k;
    endfunction
endpackage

// File: rtl/dif_doorbell.sv
module dif_doorbell
    import dif_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_wr_i,
    input  logic [NUM_SHR:0]   ctrl_data_i,
    output logic               ring_o,
    output logic               req_o,
    output logic [NUM_SHR-1:0] sel_o
);
    rq_state_e           state_q, state_d;
    logic [NUM_SHR-1:0]  sel_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RQ_LOW:  if (ctrl_wr_i && ctrl_data_i[0])  state_d = RQ_HIGH; // RING
            RQ_HIGH: if (ctrl_wr_i && !ctrl_data_i[0]) state_d = RQ_LOW;  // DISARM
            default: state_d = RQ_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RQ_LOW;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            if (ctrl_wr_i) sel_q <= ctrl_data_i[NUM_SHR:1];
        end
    end

    always_comb begin
        ring_o = 1'b0;
        req_o  = 1'b0;
        unique case (state_q)
            RQ_LOW:  ring_o = ctrl_wr_i && ctrl_data_i[0];
            RQ_HIGH: req_o  = 1'b1;
            default: ;
        endcase
    end

    assign sel_o = sel_q;
endmodule

// File: rtl/dif_src_mux.sv
module dif_src_mux
    import dif_pkg::*;
(
    input  logic [REG_W-1:0]   evt_i,
    input  logic [NUM_SHR-1:0] sel_i,
    input  logic               ring_i,
    output logic [REG_W-1:0]   set_o
);
    logic [NUM_SHR-1:0] shr_set;

    for (genvar k = 0; k < NUM_SHR; k++) begin : g_shr
        assign shr_set[k] = sel_i[k] ? evt_i[shr_dma(k)] : evt_i[shr_ser(k)];
    end

    always_comb begin
        set_o     = '0;
        set_o[0]  = evt_i[0];
        set_o[1]  = evt_i[1];
        set_o[3]  = evt_i[2];
        set_o[9]  = evt_i[3];
        set_o[4]  = evt_i[4];
        set_o[5]  = evt_i[5];
        set_o[12] = evt_i[14];
        set_o[13] = evt_i[15];
        set_o[DB_BIT] = ring_i;
        for (int k = 0; k < NUM_SHR; k++) set_o[shr_flag(k)] = shr_set[k];
    end
endmodule

// File: rtl/dif_flag_bank.sv
module dif_flag_bank
    import dif_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] set_i,
    input  logic             clr_wr_i,
    input  logic             mask_wr_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] flag_o,
    output logic [REG_W-1:0] mask_o,
    output logic             irq_o,
    output logic [IDX_W-1:0] prio_o
);
    logic [REG_W-1:0] flag_q, mask_q, clr, pend;

    assign clr = clr_wr_i ? wr_data_i : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
            mask_q <= '0;
        end else begin
            flag_q <= ((flag_q & ~clr) | set_i) & IMPL_MASK;
            if (mask_wr_i) mask_q <= wr_data_i & IMPL_MASK;
        end
    end

    assign pend  = flag_q & mask_q;
    assign irq_o = |pend;

    always_comb begin
        prio_o = '0;
        for (int i = REG_W - 1; i >= 0; i--)
            if (pend[i]) prio_o = IDX_W'(i);
    end

    assign flag_o = flag_q;
    assign mask_o = mask_q;
endmodule

// File: rtl/dual_irq_flag_ctrl.sv
module dual_irq_flag_ctrl
    import dif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              wr_sub_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [15:0]       wr_data_i,
    input  logic              rd_sub_i,
    input  logic [1:0]        rd_addr_i,
    output logic [15:0]       rd_data_o,
    input  logic [15:0]       evt0_i,
    input  logic [15:0]       evt1_i,
    output logic [1:0]        irq_o,
    output logic [3:0]        prio0_o,
    output logic [3:0]        prio1_o
);
    logic [NUM_SUB-1:0][REG_W-1:0]   flag_w, mask_w, set_w;
    logic [NUM_SUB-1:0][NUM_SHR-1:0] sel_w;
    logic [NUM_SUB-1:0][IDX_W-1:0]   prio_w;
    logic [NUM_SUB-1:0]              ring_w, req_w;

    for (genvar s = 0; s < NUM_SUB; s++) begin : g_sub
        logic hit;
        assign hit = wr_en_i && (wr_sub_i == s[0]);

        dif_doorbell u_db (
            .clk         (clk),
            .rst_n       (rst_n),
            .ctrl_wr_i   (hit && wr_addr_i == A_CTRL),
            .ctrl_data_i (wr_data_i[NUM_SHR:0]),
            .ring_o      (ring_w[s]),
            .req_o       (req_w[s]),
            .sel_o       (sel_w[s])
        );

        dif_src_mux u_mux (
            .evt_i  ((s == 0) ? evt0_i : evt1_i),
            .sel_i  (sel_w[s]),
            .ring_i (ring_w[NUM_SUB-1-s]),
            .set_o  (set_w[s])
        );

        dif_flag_bank u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_i     (set_w[s]),
            .clr_wr_i  (hit && wr_addr_i == A_FLAG),
            .mask_wr_i (hit && wr_addr_i == A_MASK),
            .wr_data_i (wr_data_i),
            .flag_o    (flag_w[s]),
            .mask_o    (mask_w[s]),
            .irq_o     (irq_o[s]),
            .prio_o    (prio_w[s])
        );
    end

    always_comb begin
        unique case (rd_addr_i)
            A_FLAG:  rd_data_o = flag_w[rd_sub_i];
            A_MASK:  rd_data_o = mask_w[rd_sub_i];
            A_CTRL:  rd_data_o = {{(REG_W-NUM_SHR-1){1'b0}}, sel_w[rd_sub_i], req_w[rd_sub_i]};
            default: rd_data_o = '0;
        endcase
    end

    assign prio0_o = prio_w[0];
    assign prio1_o = prio_w[1];
endmodule

// File: rtl/dif_checker.sv
module dif_checker
    import dif_pkg::*;
(
    input logic                            clk,
    input logic                            rst_n,
    input logic                            wr_en,
    input logic                            wr_sub,
    input logic [1:0]                      wr_addr,
    input logic [NUM_SUB-1:0][REG_W-1:0]   flag_all,
    input logic [NUM_SUB-1:0][REG_W-1:0]   mask_all,
    input logic [NUM_SUB-1:0]              ring,
    input logic [NUM_SUB-1:0]              req,
    input logic [NUM_SUB-1:0]              irq,
    input logic [IDX_W-1:0]                prio0,
    input logic [IDX_W-1:0]                prio1
);
    logic [REG_W-1:0] pend0, pend1;
    assign pend0 = flag_all[0] & mask_all[0];
    assign pend1 = flag_all[1] & mask_all[1];

    AST_RSVD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_all[0] | flag_all[1] | mask_all[0] | mask_all[1]) & RSVD_MASK) == '0); // R9
    AST_RING_LANDS_1: assert property (@(posedge clk) disable iff (!rst_n)
        ring[0] |=> flag_all[1][DB_BIT]); // R8
    AST_RING_LANDS_0: assert property (@(posedge clk) disable iff (!rst_n)
        ring[1] |=> flag_all[0][DB_BIT]); // R8
    AST_RING_NO_REPEAT_0: assert property (@(posedge clk) disable iff (!rst_n)
        ring[0] |=> (req[0] && !ring[0])); // R8
    AST_RING_NO_REPEAT_1: assert property (@(posedge clk) disable iff (!rst_n)
        ring[1] |=> (req[1] && !ring[1])); // R8
    AST_FLAG_STICKY_0: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !wr_sub && wr_addr == A_FLAG) |=>
        ((flag_all[0] & $past(flag_all[0])) == $past(flag_all[0]))); // R3
    AST_FLAG_STICKY_1: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sub && wr_addr == A_FLAG) |=>
        ((flag_all[1] & $past(flag_all[1])) == $past(flag_all[1]))); // R3
    AST_PRIO_HIT_0: assert property (@(posedge clk) disable iff (!rst_n)
        irq[0] |-> (pend0[prio0] && ((pend0 & ((REG_W'(1) << prio0) - REG_W'(1))) == '0))); // R11
    AST_PRIO_HIT_1: assert property (@(posedge clk) disable iff (!rst_n)
        irq[1] |-> (pend1[prio1] && ((pend1 & ((REG_W'(1) << prio1) - REG_W'(1))) == '0))); // R11
    AST_IDLE_0: assert property (@(posedge clk) disable iff (!rst_n)
        !irq[0] |-> (pend0 == '0 && prio0 == '0)); // R10
    AST_IDLE_1: assert property (@(posedge clk) disable iff (!rst_n)
        !irq[1] |-> (pend1 == '0 && prio1 == '0)); // R10
endmodule

bind dual_irq_flag_ctrl dif_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en_i),
    .wr_sub   (wr_sub_i),
    .wr_addr  (wr_addr_i),
    .flag_all (flag_w),
    .mask_all (mask_w),
    .ring     (ring_w),
    .req      (req_w),
    .irq      (irq_o),
    .prio0    (prio0_o),
    .prio1    (prio1_o)
);

// File: tb/dual_irq_flag_ctrl_tb_top.sv
module dual_irq_flag_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_sub = 1'b0, rd_sub = 1'b0;
    logic [1:0]  wr_addr = '0, rd_addr = '0;
    logic [15:0] wr_data = '0, evt0 = '0, evt1 = '0;
    logic [15:0] rd_data;
    logic [1:0]  irq;
    logic [3:0]  prio0, prio1;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // reference state
    int m_flag[2], m_mask[2], m_req[2], m_sel[2];
    logic [15:0] last_rd;

    always #5 clk = ~clk;

    dual_irq_flag_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_sub_i(wr_sub),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_sub_i(rd_sub),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .evt0_i(evt0), .evt1_i(evt1),
        .irq_o(irq), .prio0_o(prio0), .prio1_o(prio1)
    );

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // event vector -> flag bits, per R2 / R6
    function automatic int map_events(input int ev, input int sel);
        int r = 0;
        for (int i = 0; i < 16; i++) begin
            if (ev[i]) begin
                case (i)
                    0: r |= 1 << 0;
                    1: r |= 1 << 1;
                    2: r |= 1 << 3;
                    3: r |= 1 << 9;
                    4: r |= 1 << 4;
                    5: r |= 1 << 5;
                    8:  if (!sel[0]) r |= 1 << 6;
                    9:  if (!sel[1]) r |= 1 << 7;
                    6:  if (!sel[2]) r |= 1 << 10;
                    7:  if (!sel[3]) r |= 1 << 11;
                    10: if (sel[0]) r |= 1 << 6;
                    11: if (sel[1]) r |= 1 << 7;
                    12: if (sel[2]) r |= 1 << 10;
                    13: if (sel[3]) r |= 1 << 11;
                    14: r |= 1 << 12;
                    15: r |= 1 << 13;
                    default: ;
                endcase
            end
        end
        return r;
    endfunction

    function automatic int exp_read(input int s, input int a);
        case (a)
            0: return m_flag[s];
            1: return m_mask[s];
            2: return (m_sel[s] << 1) | m_req[s];
            default: return 0;
        endcase
    endfunction

    function automatic int exp_prio(input int s);
        int p = m_flag[s] & m_mask[s];
        for (int i = 0; i < 16; i++) if (p[i]) return i;
        return 0;
    endfunction

    task automatic step(input bit we, input bit ws, input logic [1:0] wa, input logic [15:0] wd,
                        input logic [15:0] e0, input logic [15:0] e1,
                        input bit rs, input logic [1:0] ra);
        int setv[2];
        @(negedge clk);
        wr_en = we; wr_sub = ws; wr_addr = wa; wr_data = wd;
        evt0 = e0; evt1 = e1; rd_sub = rs; rd_addr = ra;
        #1;
        last_rd = rd_data;
        case (ra)
            2'd0: check("R3 flag read", rd_data, exp_read(rs, ra));
            2'd1: check("R5 mask read", rd_data, exp_read(rs, ra));
            2'd2: check("R8 ctrl read", rd_data, exp_read(rs, ra));
            default: check("R12 unused addr", rd_data, exp_read(rs, ra));
        endcase
        check("R10 irq side0", irq[0], (m_flag[0] & m_mask[0]) != 0);
        check("R10 irq side1", irq[1], (m_flag[1] & m_mask[1]) != 0);
        check("R11 prio side0", prio0, exp_prio(0));
        check("R11 prio side1", prio1, exp_prio(1));
        @(posedge clk);
        setv[0] = map_events(e0, m_sel[0]);
        setv[1] = map_events(e1, m_sel[1]);
        if (we && wa == 2'd2 && wd[0] && m_req[ws] == 0) setv[1-ws] |= 1 << 14;
        if (we) begin
            case (wa)
                2'd0: m_flag[ws] &= ~int'(wd);
                2'd1: m_mask[ws] = wd & 16'h7EFB;
                2'd2: begin m_req[ws] = wd[0]; m_sel[ws] = wd[4:1]; end
                default: ;
            endcase
        end
        m_flag[0] |= setv[0];
        m_flag[1] |= setv[1];
    endtask

    task automatic idle_rd(input bit s, input logic [1:0] a);
        step(0, 0, 2'd0, 16'h0, 16'h0, 16'h0, s, a);
    endtask

    task automatic wr(input bit s, input logic [1:0] a, input logic [15:0] d);
        step(1, s, a, d, 16'h0, 16'h0, s, a);
    endtask

    task automatic pulse(input logic [15:0] e0, input logic [15:0] e1);
        step(0, 0, 2'd0, 16'h0, e0, e1, 0, 2'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        vectors++; miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int s = 0; s < 2; s++) begin
            m_flag[s] = 0; m_mask[s] = 0; m_req[s] = 0; m_sel[s] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < 4; a++) begin
                idle_rd(s[0], a[1:0]);
                check("R1 reset read", last_rd, 0);
            end
        check("R1 reset irq", irq, 0);
        check("R1 reset prio", {prio1, prio0}, 0);

        // R2 / R6: every event alone, serial source then DMA source
        for (int pass = 0; pass < 2; pass++) begin
            wr(0, 2'd2, pass ? 16'h001E : 16'h0000);
            for (int i = 0; i < 16; i++) begin
                wr(0, 2'd0, 16'hFFFF);
                pulse(16'(1 << i), 16'h0);
                idle_rd(0, 2'd0);
                if (i >= 6 && i <= 13)
                    check("R6 shared source map", last_rd, map_events(1 << i, pass ? 15 : 0));
                else
                    check("R2 event map", last_rd, map_events(1 << i, 0));
            end
        end
        wr(0, 2'd2, 16'h0000);
        wr(0, 2'd0, 16'hFFFF);

        // R4: set beats clear in the same cycle
        pulse(16'h0001, 16'h0);
        step(1, 0, 2'd0, 16'h0001, 16'h0001, 16'h0, 0, 2'd0);
        idle_rd(0, 2'd0);
        check("R4 set wins", last_rd & 1, 1);
        wr(0, 2'd0, 16'h0001);
        idle_rd(0, 2'd0);
        check("R3 w1c clears", last_rd, 0);

        // R7: select change leaves latched flag alone
        pulse(16'h0100, 16'h0);
        wr(0, 2'd2, 16'h0002);
        idle_rd(0, 2'd0);
        check("R7 latched kept", last_rd, 16'h0040);
        wr(0, 2'd0, 16'hFFFF);
        pulse(16'h0100, 16'h0);
        idle_rd(0, 2'd0);
        check("R7 new source only", last_rd, 0);
        wr(0, 2'd2, 16'h0000);

        // R9: reserved bits
        wr(1, 2'd1, 16'hFFFF);
        idle_rd(1, 2'd1);
        check("R9 mask reserved", last_rd, 16'h7EFB);
        pulse(16'h0, 16'hFFFF);
        idle_rd(1, 2'd0);
        check("R9 flag reserved", last_rd & 16'h8104, 0);
        wr(1, 2'd0, 16'hFFFF);

        // R8: doorbell edges both ways
        wr(0, 2'd2, 16'h0001);
        idle_rd(1, 2'd0);
        check("R8 ring 0->1", last_rd, 16'h4000);
        wr(1, 2'd0, 16'h4000);
        wr(0, 2'd2, 16'h0001);
        idle_rd(1, 2'd0);
        check("R8 no re-ring", last_rd, 0);
        wr(0, 2'd2, 16'h0000);
        wr(0, 2'd2, 16'h0001);
        idle_rd(1, 2'd0);
        check("R8 re-armed", last_rd, 16'h4000);
        wr(1, 2'd2, 16'h0001);
        idle_rd(0, 2'd0);
        check("R8 ring 1->0", last_rd, 16'h4000);

        // R10 / R11: priority with partial mask
        wr(0, 2'd1, 16'h0FF0);
        pulse(16'h0005, 16'h0);
        pulse(16'h4030, 16'h0);
        idle_rd(0, 2'd3);
        check("R11 lowest enabled", prio0, 4);
        check("R12 addr3 zero", last_rd, 0);
        wr(0, 2'd0, 16'h0030);
        idle_rd(0, 2'd0);
        check("R10 masked-out only", irq[0], 0);

        // mixed traffic, compared every cycle
        for (int n = 0; n < 600; n++) begin
            int r = $urandom;
            step((r % 4) == 0, r[4], r[6:5], 16'($urandom),
                 16'($urandom & $urandom & $urandom), 16'($urandom & $urandom & $urandom),
                 r[8], r[10:9]);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule